// File: doc/BRIEF.md
# MMU Data Store Path Controller

This block takes one processor data store at a time (byte, halfword or word) and carries it through a simplified memory-management data path. A store is accepted on a valid/ready request port. The controller first looks the address up in the instruction cache and updates that line on a hit. It then either writes memory directly at the untranslated address, when translation is off, or it runs an alignment check, a translation query and lookups in the main and mini data caches. After that the store goes to exactly one sink: a cache update port, a write-buffer port or a direct memory write port. Every store ends with a one-cycle done pulse that carries a fault code.

All ports that carry a request out of the block follow valid/ready rules. Once a valid is raised, it and its payload stay unchanged until the sink raises ready, and the transfer happens on the clock edge where both are high. The sink may hold ready low for any number of cycles to apply back-pressure. On the lookup and translation ports the responder answers with a response-valid, which may come in the same cycle as the request or later; the request stays high until the response arrives. The request port itself is ready only while the controller is idle, so a caller that holds a store waits until the previous store's done pulse has gone by. The configuration inputs (translation enable, alignment-check enable, write-buffer enable) are sampled when a store is accepted.

A store that misses both data caches on a non-bufferable page must first empty the write buffer. The controller holds a drain request until the drain-done input is seen, and only then issues the memory write.

Top module: `mmu_store_ctrl`

## Requirements
- R1: `req_ready` is high only when the controller is idle, and only one store is in flight. At most one of the lookup request, translation request, cache update, write-buffer, memory write and drain request outputs is high in any cycle. `done_valid` is a single-cycle pulse, and `req_ready` is high in the cycle after it.
- R2: Size encoding: 0 = byte, 1 = halfword, 2 = word. Lookup select encoding: 0 = instruction cache, 1 = main data cache, 2 = mini data cache. Every accepted store first issues an instruction-cache lookup. On a hit, the store is sent to the cache update port with select 0, at its virtual address and with its data and size, and the data path then continues.
- R3: With translation disabled, the store is written to memory at its virtual address with its own size and data. No alignment check and no translation request take place, and the fault code is 0.
- R4: With alignment checking enabled and translation on, a word store with `va[1:0]` not 00, or a halfword store with `va[0]` = 1, ends with fault code `ALIGN_FAULT` (default 1). It makes no translation request and no write on the data-cache, write-buffer or memory ports.
- R5: A nonzero translation fault code takes precedence over a nonzero permission fault code. Either one aborts the store with that code, without any data-cache lookup or write.
- R6: With no fault, the main data cache is looked up after the instruction cache, and the mini data cache is looked up only if the main cache misses. A hit in either sends the store to the cache update port with that cache's select.
- R7: On a miss in both data caches to a bufferable page with the write buffer enabled, the store goes to the write-buffer port with a length of 4, 2 or 1 bytes for word, halfword or byte.
- R8: On a miss in both data caches to a bufferable page with the write buffer disabled, the store is written directly to memory.
- R9: On a miss in both data caches to a non-bufferable page, `drain_req` is raised and held until `drain_done` is seen. The direct memory write is issued only after that, and never while `drain_req` is high.
- R10: The translated write address is `pa & ~3` for a word, `pa | (va & 2)` for a halfword and `pa | (va & 3)` for a byte. The same address is used on the write-buffer and memory ports.
- R11: A raised `cu_valid`, `wb_valid` or `mw_valid` stays high with a stable payload until its ready is seen.
- R12: A store that completes without a fault reports fault code 0 on its done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mmu_en | input | 1 | Translation enable, sampled at accept |
| cfg_align_en | input | 1 | Alignment-check enable, sampled at accept |
| cfg_wb_en | input | 1 | Write-buffer enable, sampled at accept |
| req_valid | input | 1 | Store request valid |
| req_ready | output | 1 | Controller idle and accepting a store |
| req_va | input | ADDR_W | Store virtual address |
| req_data | input | DATA_W | Store data |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| lk_req_valid | output | 1 | Cache lookup request |
| lk_req_sel | output | 2 | Cache to look up (0 instr, 1 main, 2 mini) |
| lk_req_va | output | ADDR_W | Lookup address |
| lk_rsp_valid | input | 1 | Lookup answer present |
| lk_rsp_hit | input | 1 | Lookup hit |
| xl_req_valid | output | 1 | Translation request |
| xl_req_va | output | ADDR_W | Address to translate |
| xl_rsp_valid | input | 1 | Translation answer present |
| xl_rsp_xfault | input | FAULT_W | Translation fault code, 0 if none |
| xl_rsp_pfault | input | FAULT_W | Permission fault code, 0 if none |
| xl_rsp_pa | input | ADDR_W | Physical address |
| xl_rsp_buf | input | 1 | Page is bufferable |
| cu_valid | output | 1 | Cache update valid |
| cu_ready | input | 1 | Cache update accepted |
| cu_sel | output | 2 | Cache to update |
| cu_va | output | ADDR_W | Update virtual address |
| cu_data | output | DATA_W | Update data |
| cu_size | output | 2 | Update size |
| wb_valid | output | 1 | Write-buffer post valid |
| wb_ready | input | 1 | Write buffer accepts |
| wb_addr | output | ADDR_W | Post physical address |
| wb_data | output | DATA_W | Post data |
| wb_len | output | 3 | Post length in bytes |
| mw_valid | output | 1 | Direct memory write valid |
| mw_ready | input | 1 | Memory accepts |
| mw_addr | output | ADDR_W | Write address |
| mw_data | output | DATA_W | Write data |
| mw_size | output | 2 | Write size |
| drain_req | output | 1 | Request to empty the write buffer |
| drain_done | input | 1 | Write buffer has emptied |
| done_valid | output | 1 | Store finished pulse |
| done_fault | output | FAULT_W | Fault code, 0 on success |

## Verification
An accepted store causes its instruction-cache lookup in the next cycle. Each lookup or translation step lasts exactly one cycle when the responder answers at once, and each sink step lasts until the cycle in which its ready is seen. The done pulse comes in the cycle after the final transfer or fault decision. The bench drives readies and the drain-done input at the falling edge, and it records a transfer only when valid and the new ready are both high, which is the transfer the next rising edge completes. It waits for the done pulse and then for one more falling edge, where `req_ready` must be back, so every comparison is made on a log of completed handshakes rather than at a fixed cycle count.

// File: rtl/mst_pkg.sv
package mst_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [1:0] SEL_ICACHE = 2'd0;
  localparam logic [1:0] SEL_MAIN   = 2'd1;
  localparam logic [1:0] SEL_MINI   = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ILOOK, ST_IUPD, ST_XLAT, ST_MLOOK, ST_NLOOK,
    ST_DUPD, ST_WBW, ST_DRAIN, ST_MEMW, ST_DONE
  } state_e;

  function automatic logic is_word(input logic [1:0] sz);
    return sz[1];
  endfunction

  function automatic logic [2:0] byte_len(input logic [1:0] sz);
    if (is_word(sz)) return 3'd4;
    else if (sz == SZ_HALF) return 3'd2;
    else return 3'd1;
  endfunction
endpackage

// File: rtl/mst_align_chk.sv
module mst_align_chk
  import mst_pkg::*;
(
  input  logic       en,
  input  logic [1:0] va_lo,
  input  logic [1:0] size,
  output logic       misaligned
);
  logic word_bad;
  logic half_bad;

  always_comb begin
    word_bad   = is_word(size) && (va_lo != 2'b00);
    half_bad   = (size == SZ_HALF) && va_lo[0];
    misaligned = en && (word_bad || half_bad);
  end
endmodule

// File: rtl/mst_addr_form.sv
module mst_addr_form
  import mst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        va_lo,
  input  logic [1:0]        size,
  input  logic              translated,
  output logic [ADDR_W-1:0] addr
);
  assign addr[ADDR_W-1:2] = base[ADDR_W-1:2];

  for (genvar gi = 0; gi < 2; gi++) begin : g_low
    logic take_va;
    logic keep_base;
    always_comb begin
      keep_base = !is_word(size);
      take_va   = (size == SZ_BYTE) || ((size == SZ_HALF) && (gi == 1));
      if (!translated) addr[gi] = base[gi];
      else addr[gi] = (keep_base & base[gi]) | (take_va & va_lo[gi]);
    end
  end
endmodule

// File: rtl/mst_capture.sv
module mst_capture #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req,
  input  logic              cap_xl,
  input  logic [ADDR_W-1:0] in_va,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        in_size,
  input  logic              in_mmu_en,
  input  logic              in_align_en,
  input  logic              in_wb_en,
  input  logic [ADDR_W-1:0] in_pa,
  input  logic              in_buf,
  output logic [ADDR_W-1:0] va_q,
  output logic [DATA_W-1:0] data_q,
  output logic [1:0]        size_q,
  output logic              mmu_en_q,
  output logic              align_en_q,
  output logic              wb_en_q,
  output logic [ADDR_W-1:0] pa_q,
  output logic              buf_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q       <= '0;
      data_q     <= '0;
      size_q     <= '0;
      mmu_en_q   <= 1'b0;
      align_en_q <= 1'b0;
      wb_en_q    <= 1'b0;
    end else if (cap_req) begin
      va_q       <= in_va;
      data_q     <= in_data;
      size_q     <= in_size;
      mmu_en_q   <= in_mmu_en;
      align_en_q <= in_align_en;
      wb_en_q    <= in_wb_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_q  <= '0;
      buf_q <= 1'b0;
    end else if (cap_xl) begin
      pa_q  <= in_pa;
      buf_q <= in_buf;
    end
  end
endmodule

// File: rtl/mst_fsm.sv
module mst_fsm
  import mst_pkg::*;
#(
  parameter int              FAULT_W     = 4,
  parameter logic [FAULT_W-1:0] ALIGN_FAULT = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               mmu_en_q,
  input  logic               wb_en_q,
  input  logic               buf_q,
  input  logic               misaligned,
  input  logic               lk_rsp_valid,
  input  logic               lk_rsp_hit,
  input  logic               xl_rsp_valid,
  input  logic [FAULT_W-1:0] xl_rsp_xfault,
  input  logic [FAULT_W-1:0] xl_rsp_pfault,
  input  logic               cu_ready,
  input  logic               wb_ready,
  input  logic               mw_ready,
  input  logic               drain_done,
  output logic               req_ready,
  output logic               cap_req,
  output logic               cap_xl,
  output logic               lk_req_valid,
  output logic [1:0]         lk_req_sel,
  output logic               xl_req_valid,
  output logic               cu_valid,
  output logic [1:0]         cu_sel,
  output logic               wb_valid,
  output logic               mw_valid,
  output logic               drain_req,
  output logic               translated,
  output logic               done_valid,
  output logic [FAULT_W-1:0] done_fault
);
  state_e             state, state_n;
  logic [1:0]         dsel_q, dsel_n;
  logic [FAULT_W-1:0] fault_q, fault_n;
  state_e             after_icache;
  state_e             after_miss;

  // Where the store goes once the instruction-cache step is over.
  always_comb begin
    if (!mmu_en_q) after_icache = ST_MEMW;
    else if (misaligned) after_icache = ST_DONE;
    else after_icache = ST_XLAT;
  end

  // Sink for a store that missed both data caches.
  always_comb begin
    if (!buf_q) after_miss = ST_DRAIN;
    else if (wb_en_q) after_miss = ST_WBW;
    else after_miss = ST_MEMW;
  end

  always_comb begin
    state_n = state;
    dsel_n  = dsel_q;
    fault_n = fault_q;
    cap_req = 1'b0;
    cap_xl  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          cap_req = 1'b1;
          fault_n = '0;
          state_n = ST_ILOOK;
        end
      end
      ST_ILOOK: begin
        if (lk_rsp_valid) begin
          if (lk_rsp_hit) state_n = ST_IUPD;
          else begin
            state_n = after_icache;
            if (after_icache == ST_DONE) fault_n = ALIGN_FAULT;
          end
        end
      end
      ST_IUPD: begin
        if (cu_ready) begin
          state_n = after_icache;
          if (after_icache == ST_DONE) fault_n = ALIGN_FAULT;
        end
      end
      ST_XLAT: begin
        if (xl_rsp_valid) begin
          if (xl_rsp_xfault != '0) begin
            fault_n = xl_rsp_xfault;
            state_n = ST_DONE;
          end else if (xl_rsp_pfault != '0) begin
            fault_n = xl_rsp_pfault;
            state_n = ST_DONE;
          end else begin
            cap_xl  = 1'b1;
            state_n = ST_MLOOK;
          end
        end
      end
      ST_MLOOK: begin
        if (lk_rsp_valid) begin
          if (lk_rsp_hit) begin
            dsel_n  = SEL_MAIN;
            state_n = ST_DUPD;
          end else state_n = ST_NLOOK;
        end
      end
      ST_NLOOK: begin
        if (lk_rsp_valid) begin
          if (lk_rsp_hit) begin
            dsel_n  = SEL_MINI;
            state_n = ST_DUPD;
          end else state_n = after_miss;
        end
      end
      ST_DUPD:  if (cu_ready)   state_n = ST_DONE;
      ST_WBW:   if (wb_ready)   state_n = ST_DONE;
      ST_MEMW:  if (mw_ready)   state_n = ST_DONE;
      ST_DRAIN: if (drain_done) state_n = ST_MEMW;
      ST_DONE:  state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      dsel_q  <= SEL_MAIN;
      fault_q <= '0;
    end else begin
      state   <= state_n;
      dsel_q  <= dsel_n;
      fault_q <= fault_n;
    end
  end

  always_comb begin
    req_ready    = (state == ST_IDLE);
    lk_req_valid = (state == ST_ILOOK) || (state == ST_MLOOK) || (state == ST_NLOOK);
    unique case (state)
      ST_MLOOK: lk_req_sel = SEL_MAIN;
      ST_NLOOK: lk_req_sel = SEL_MINI;
      default:  lk_req_sel = SEL_ICACHE;
    endcase
    xl_req_valid = (state == ST_XLAT);
    cu_valid     = (state == ST_IUPD) || (state == ST_DUPD);
    cu_sel       = (state == ST_IUPD) ? SEL_ICACHE : dsel_q;
    wb_valid     = (state == ST_WBW);
    mw_valid     = (state == ST_MEMW);
    drain_req    = (state == ST_DRAIN);
    translated   = mmu_en_q;
    done_valid   = (state == ST_DONE);
    done_fault   = fault_q;
  end
endmodule

// File: rtl/mmu_store_ctrl.sv
module mmu_store_ctrl
  import mst_pkg::*;
#(
  parameter int                 ADDR_W      = 32,
  parameter int                 DATA_W      = 32,
  parameter int                 FAULT_W     = 4,
  parameter logic [FAULT_W-1:0] ALIGN_FAULT = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_mmu_en,
  input  logic               cfg_align_en,
  input  logic               cfg_wb_en,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_va,
  input  logic [DATA_W-1:0]  req_data,
  input  logic [1:0]         req_size,
  output logic               lk_req_valid,
  output logic [1:0]         lk_req_sel,
  output logic [ADDR_W-1:0]  lk_req_va,
  input  logic               lk_rsp_valid,
  input  logic               lk_rsp_hit,
  output logic               xl_req_valid,
  output logic [ADDR_W-1:0]  xl_req_va,
  input  logic               xl_rsp_valid,
  input  logic [FAULT_W-1:0] xl_rsp_xfault,
  input  logic [FAULT_W-1:0] xl_rsp_pfault,
  input  logic [ADDR_W-1:0]  xl_rsp_pa,
  input  logic               xl_rsp_buf,
  output logic               cu_valid,
  input  logic               cu_ready,
  output logic [1:0]         cu_sel,
  output logic [ADDR_W-1:0]  cu_va,
  output logic [DATA_W-1:0]  cu_data,
  output logic [1:0]         cu_size,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [ADDR_W-1:0]  wb_addr,
  output logic [DATA_W-1:0]  wb_data,
  output logic [2:0]         wb_len,
  output logic               mw_valid,
  input  logic               mw_ready,
  output logic [ADDR_W-1:0]  mw_addr,
  output logic [DATA_W-1:0]  mw_data,
  output logic [1:0]         mw_size,
  output logic               drain_req,
  input  logic               drain_done,
  output logic               done_valid,
  output logic [FAULT_W-1:0] done_fault
);
  logic              cap_req, cap_xl;
  logic [ADDR_W-1:0] va_q, pa_q, base, wr_addr;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        size_q;
  logic              mmu_en_q, align_en_q, wb_en_q, buf_q;
  logic              misaligned, translated;

  mst_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .cap_xl(cap_xl),
    .in_va(req_va), .in_data(req_data), .in_size(req_size),
    .in_mmu_en(cfg_mmu_en), .in_align_en(cfg_align_en), .in_wb_en(cfg_wb_en),
    .in_pa(xl_rsp_pa), .in_buf(xl_rsp_buf),
    .va_q(va_q), .data_q(data_q), .size_q(size_q), .mmu_en_q(mmu_en_q),
    .align_en_q(align_en_q), .wb_en_q(wb_en_q), .pa_q(pa_q), .buf_q(buf_q)
  );

  mst_align_chk u_align (
    .en(align_en_q), .va_lo(va_q[1:0]), .size(size_q), .misaligned(misaligned)
  );

  mst_fsm #(.FAULT_W(FAULT_W), .ALIGN_FAULT(ALIGN_FAULT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .mmu_en_q(mmu_en_q), .wb_en_q(wb_en_q), .buf_q(buf_q), .misaligned(misaligned),
    .lk_rsp_valid(lk_rsp_valid), .lk_rsp_hit(lk_rsp_hit),
    .xl_rsp_valid(xl_rsp_valid), .xl_rsp_xfault(xl_rsp_xfault),
    .xl_rsp_pfault(xl_rsp_pfault), .cu_ready(cu_ready), .wb_ready(wb_ready),
    .mw_ready(mw_ready), .drain_done(drain_done),
    .req_ready(req_ready), .cap_req(cap_req), .cap_xl(cap_xl),
    .lk_req_valid(lk_req_valid), .lk_req_sel(lk_req_sel),
    .xl_req_valid(xl_req_valid), .cu_valid(cu_valid), .cu_sel(cu_sel),
    .wb_valid(wb_valid), .mw_valid(mw_valid), .drain_req(drain_req),
    .translated(translated), .done_valid(done_valid), .done_fault(done_fault)
  );

  assign base = translated ? pa_q : va_q;

  mst_addr_form #(.ADDR_W(ADDR_W)) u_addr (
    .base(base), .va_lo(va_q[1:0]), .size(size_q),
    .translated(translated), .addr(wr_addr)
  );

  assign lk_req_va = va_q;
  assign xl_req_va = va_q;
  assign cu_va     = va_q;
  assign cu_data   = data_q;
  assign cu_size   = size_q;
  assign wb_addr   = wr_addr;
  assign wb_data   = data_q;
  assign wb_len    = byte_len(size_q);
  assign mw_addr   = wr_addr;
  assign mw_data   = data_q;
  assign mw_size   = size_q;
endmodule

// File: rtl/mst_checker.sv
module mst_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              lk_req_valid,
  input logic              xl_req_valid,
  input logic              cu_valid,
  input logic              cu_ready,
  input logic [1:0]        cu_sel,
  input logic [ADDR_W-1:0] cu_va,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [DATA_W-1:0] wb_data,
  input logic [2:0]        wb_len,
  input logic              mw_valid,
  input logic              mw_ready,
  input logic [ADDR_W-1:0] mw_addr,
  input logic [DATA_W-1:0] mw_data,
  input logic              drain_req,
  input logic              drain_done,
  input logic              done_valid
);
  a_r1_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_req_valid, xl_req_valid, cu_valid, wb_valid, mw_valid, drain_req}));

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && req_ready);

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cu_valid || wb_valid || mw_valid || drain_req) |-> !req_ready);

  a_r7_wb_len: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_len == 3'd1 || wb_len == 3'd2 || wb_len == 3'd4));

  a_r9_no_mem_while_draining: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> !mw_valid);

  a_r9_drain_held: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req && !drain_done |=> drain_req);

  a_r9_drain_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req && drain_done |=> mw_valid);

  a_r11_mw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

  a_r11_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data) && $stable(wb_len));

  a_r11_cu_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cu_valid && !cu_ready |=> cu_valid && $stable(cu_sel) && $stable(cu_va));
endmodule

bind mmu_store_ctrl mst_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .lk_req_valid(lk_req_valid), .xl_req_valid(xl_req_valid),
  .cu_valid(cu_valid), .cu_ready(cu_ready), .cu_sel(cu_sel), .cu_va(cu_va),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
  .wb_data(wb_data), .wb_len(wb_len),
  .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
  .drain_req(drain_req), .drain_done(drain_done), .done_valid(done_valid)
);

// File: tb/mmu_store_ctrl_bench.sv
module mmu_store_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cfg_mmu_en = 0, cfg_align_en = 0, cfg_wb_en = 0;
  logic        req_valid = 0, req_ready;
  logic [31:0] req_va = 0, req_data = 0;
  logic [1:0]  req_size = 0;
  logic        lk_req_valid, lk_rsp_valid, lk_rsp_hit;
  logic [1:0]  lk_req_sel;
  logic [31:0] lk_req_va, xl_req_va;
  logic        xl_req_valid, xl_rsp_valid, xl_rsp_buf;
  logic [3:0]  xl_rsp_xfault, xl_rsp_pfault;
  logic [31:0] xl_rsp_pa;
  logic        cu_valid, cu_ready = 0, wb_valid, wb_ready = 0, mw_valid, mw_ready = 0;
  logic [1:0]  cu_sel, cu_size, mw_size;
  logic [31:0] cu_va, cu_data, wb_addr, wb_data, mw_addr, mw_data;
  logic [2:0]  wb_len;
  logic        drain_req, drain_done = 0, done_valid;
  logic [3:0]  done_fault;

  // scenario for the responders
  logic sc_ih, sc_mh, sc_nh, sc_buf;
  logic [3:0] sc_xf, sc_pf;
  logic [31:0] sc_pa;

  assign lk_rsp_valid  = lk_req_valid;
  assign lk_rsp_hit    = (lk_req_sel == 2'd0) ? sc_ih : (lk_req_sel == 2'd1) ? sc_mh : sc_nh;
  assign xl_rsp_valid  = xl_req_valid;
  assign xl_rsp_xfault = sc_xf;
  assign xl_rsp_pfault = sc_pf;
  assign xl_rsp_pa     = sc_pa;
  assign xl_rsp_buf    = sc_buf;

  mmu_store_ctrl u_mmu_store_ctrl (.*);

  int checks = 0, failures = 0, cyc = 0;
  logic done_seen, drained, mw_after_drain;
  logic [3:0] done_code;
  logic [7:0] lk_seq; int lk_n, xl_n;
  logic [3:0] cu_seq; int cu_n, wb_n, mw_n;
  logic [31:0] cu_va_l, cu_data_l, wb_addr_l, wb_data_l, mw_addr_l, mw_data_l;
  logic [1:0] cu_size_l, mw_size_l;
  logic [2:0] wb_len_l;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    cu_ready   = ($urandom % 4) != 0;
    wb_ready   = ($urandom % 4) != 0;
    mw_ready   = ($urandom % 4) != 0;
    drain_done = drain_req && (($urandom % 3) == 0);
    if (lk_req_valid) begin lk_seq = {lk_seq[5:0], lk_req_sel}; lk_n++; end
    if (xl_req_valid) xl_n++;
    if (cu_valid && cu_ready) begin
      cu_seq = {cu_seq[1:0], cu_sel}; cu_n++;
      cu_va_l = cu_va; cu_data_l = cu_data; cu_size_l = cu_size;
    end
    if (wb_valid && wb_ready) begin
      wb_n++; wb_addr_l = wb_addr; wb_data_l = wb_data; wb_len_l = wb_len;
    end
    if (drain_req && drain_done) drained = 1'b1;
    if (mw_valid && mw_ready) begin
      mw_n++; mw_addr_l = mw_addr; mw_data_l = mw_data; mw_size_l = mw_size;
      mw_after_drain = drained;
    end
    if (done_valid) begin done_seen = 1'b1; done_code = done_fault; end
    if (cyc > 150000) begin
      failures++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  function automatic logic [31:0] exp_addr(input logic [31:0] pa, input logic [31:0] va,
                                           input logic [1:0] sz);
    if (sz[1]) return pa & ~32'd3;
    else if (sz == 2'd1) return pa | (va & 32'd2);
    else return pa | (va & 32'd3);
  endfunction

  task automatic run_store(input logic [31:0] va, input logic [31:0] dat, input logic [1:0] sz,
                           input logic mmu, input logic alen, input logic wben,
                           input logic ih, input logic mh, input logic nh,
                           input logic [3:0] xf, input logic [3:0] pf,
                           input logic [31:0] pa, input logic bf);
    logic af, dpath, dhit, to_wb, to_mw, need_drain;
    logic [3:0] ef; logic [7:0] eseq; int en; logic [3:0] ecu; int ecn;
    logic [31:0] eaddr;
    @(negedge clk);
    sc_ih = ih; sc_mh = mh; sc_nh = nh; sc_xf = xf; sc_pf = pf; sc_pa = pa; sc_buf = bf;
    cfg_mmu_en = mmu; cfg_align_en = alen; cfg_wb_en = wben;
    lk_seq = 0; lk_n = 0; xl_n = 0; cu_seq = 0; cu_n = 0; wb_n = 0; mw_n = 0;
    drained = 0; mw_after_drain = 0; done_seen = 0;
    req_va = va; req_data = dat; req_size = sz; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done_seen) @(negedge clk);
    @(negedge clk);
    chk("R1 ready after done", {63'd0, req_ready}, 64'd1);

    af = alen && ((sz == 2'd2 && va[1:0] != 2'b00) || (sz == 2'd1 && va[0]));
    dpath = mmu && !af && xf == 0 && pf == 0;
    dhit = dpath && (mh || nh);
    to_wb = dpath && !dhit && bf && wben;
    to_mw = !mmu || (dpath && !dhit && !(bf && wben));
    need_drain = dpath && !dhit && !bf;
    if (!mmu) ef = 0; else if (af) ef = 4'd1; else if (xf != 0) ef = xf;
    else if (pf != 0) ef = pf; else ef = 0;
    if (!dpath) begin eseq = 8'h00; en = 1; end
    else if (mh) begin eseq = 8'h01; en = 2; end
    else begin eseq = 8'h06; en = 3; end
    ecu = 0; ecn = 0;
    if (ih) begin ecu = {ecu[1:0], 2'd0}; ecn++; end
    if (dhit) begin ecu = {ecu[1:0], (mh ? 2'd1 : 2'd2)}; ecn++; end
    eaddr = mmu ? exp_addr(pa, va, sz) : va;

    if (!mmu) chk("R3 fault", {60'd0, done_code}, {60'd0, ef});
    else if (af) chk("R4 fault", {60'd0, done_code}, {60'd0, ef});
    else if (xf != 0 || pf != 0) chk("R5 fault", {60'd0, done_code}, {60'd0, ef});
    else chk("R12 fault", {60'd0, done_code}, 64'd0);
    chk("R6 lookup order", {lk_seq, lk_n[7:0]}, {eseq, en[7:0]});
    chk("R5 xlat requests", xl_n, (mmu && !af) ? 1 : 0);
    chk("R2 cache updates", {cu_seq, cu_n[7:0]}, {ecu, ecn[7:0]});
    if (ecn != 0) chk("R2 update payload", {cu_va_l, cu_data_l}, {va, dat});
    chk("R7 wb posts", wb_n, to_wb ? 1 : 0);
    if (to_wb) begin
      chk("R10 wb addr", wb_addr_l, eaddr);
      chk("R7 wb len/data", {29'd0, wb_len_l, wb_data_l}, {29'd0, (sz[1] ? 3'd4 : sz[0] ? 3'd2 : 3'd1), dat});
    end
    chk(mmu ? "R8 mem writes" : "R3 mem writes", mw_n, to_mw ? 1 : 0);
    if (to_mw) begin
      chk(mmu ? "R10 mem addr" : "R3 mem addr", mw_addr_l, eaddr);
      chk("R3 mem data/size", {30'd0, mw_size_l, mw_data_l}, {30'd0, sz, dat});
      chk("R9 drain before write", {63'd0, mw_after_drain}, {63'd0, need_drain});
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    sc_ih = 0; sc_mh = 0; sc_nh = 0; sc_xf = 0; sc_pf = 0; sc_pa = 0; sc_buf = 0;
    repeat (4) @(negedge clk);
    chk("R1 reset idle", {58'd0, req_ready, cu_valid, wb_valid, mw_valid, drain_req, done_valid},
        {58'd0, 6'b100000});
    rst_n = 1'b1;
    // directed corners
    run_store(32'h1000_0003, 32'hdead_beef, 2'd2, 0, 1, 1, 0, 0, 0, 4'd5, 4'd6, 32'h0, 1);  // R3 misaligned, off
    run_store(32'h2000_0001, 32'h1234, 2'd1, 1, 1, 1, 1, 0, 0, 0, 0, 32'h8000_0000, 1);     // R4 + R2 hit
    run_store(32'h2000_0002, 32'hcafe_f00d, 2'd2, 1, 1, 1, 0, 1, 1, 0, 0, 32'h8000_0000, 1); // R4 word
    run_store(32'h3000_0006, 32'h55, 2'd2, 1, 0, 1, 0, 0, 0, 0, 0, 32'h9000_0003, 1);        // R10 word masks
    run_store(32'h4000_0000, 32'h66, 2'd2, 1, 1, 1, 0, 0, 0, 4'd7, 4'd9, 32'h0, 1);          // R5 precedence
    run_store(32'h4000_0000, 32'h67, 2'd2, 1, 1, 1, 0, 0, 0, 4'd0, 4'd9, 32'h0, 1);          // R5 permission
    run_store(32'h5000_0004, 32'h77, 2'd2, 1, 1, 1, 0, 1, 1, 0, 0, 32'h0, 1);                // R6 main first
    run_store(32'h5000_0008, 32'h78, 2'd2, 1, 1, 1, 0, 0, 1, 0, 0, 32'h0, 0);                // R6 mini
    run_store(32'h6000_0003, 32'hab, 2'd0, 1, 1, 1, 1, 0, 0, 0, 0, 32'ha000_0010, 0);        // R9 + R2
    run_store(32'h6000_0002, 32'hbeef, 2'd1, 1, 1, 1, 0, 0, 0, 0, 0, 32'ha000_0011, 1);      // R7 half
    run_store(32'h6000_0001, 32'hcd, 2'd0, 1, 1, 0, 0, 0, 0, 0, 0, 32'ha000_0020, 1);        // R8
    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic [1:0] sz; logic [31:0] va;
      sz = 2'($urandom % 3);
      va = $urandom;
      if (($urandom % 2) == 0) va[1:0] = 2'b00;
      run_store(va, $urandom, sz, ($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 2) == 0,
                ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
                (($urandom % 8) == 0) ? 4'($urandom % 14 + 2) : 4'd0,
                (($urandom % 8) == 0) ? 4'($urandom % 14 + 2) : 4'd0,
                $urandom, ($urandom % 2) == 0);
    end
    finish_run();
  end
endmodule